// File: doc/BRIEF.md
# Flash Instruction Sequence Builder

This block takes one serial-flash operation and writes it as an instruction sequence into the controller's sequence table. The operation is described by an opcode, how many address and dummy bytes it has, whether it moves data and in which direction, a bus width for each phase, and a double-rate flag for each phase. The block turns these into up to eight 16-bit instructions and packs them two per 32-bit word, which gives four words.

On a start pulse the block first unlocks the table. It then writes the four words into the last slot of the table and locks the table again. It drives the register bus one write at a time and waits while the bus holds its ready input low. A one-cycle done pulse marks the end. The number of slots in the table is set at build time, and that number fixes where the last slot sits.

Top module: `flut_seq_builder`

## Requirements
- R1: Each instruction is 16 bits, laid out as {opcode[5:0], pad[1:0], operand[7:0]}. The pad field is log2 of the bus width, so widths 1, 2, 4 and 8 give pads 0, 1, 2 and 3. Instruction i is placed in word i/2. An even i goes in bits 15:0 and an odd i goes in bits 31:16.
- R2: Instructions follow a fixed phase order: command, then address, then dummy, then data. A phase that is absent emits nothing. Every unused instruction position is zero.
- R3: A single-rate command emits one instruction with opcode 0x01. Its operand is the low byte of the command code and its pad comes from the command width.
- R4: A double-rate command emits two instructions, each with opcode 0x21. The first carries the high byte of the command code and the second carries the low byte.
- R5: A nonzero address byte count emits one address instruction. Its opcode is 0x02, or 0x22 when the address phase is double-rate. Its operand is the byte count times 8 and its pad comes from the address width.
- R6: A nonzero dummy byte count emits one dummy instruction. Its opcode is 0x0C, or 0x2C when the dummy phase is double-rate. Its pad comes from the data width, not from the dummy width. Its operand is the dummy byte count times 8, shifted right by the pad of the dummy width.
- R7: A nonzero data length emits one data instruction with operand 0. The opcode is 0x09 for a single-rate read, 0x29 for a double-rate read, 0x08 for a single-rate write and 0x28 for a double-rate write.
- R8: Each operation makes exactly six writes, in this order. First comes UNLOCK_KEY at LOCK_ADDR. Then come words 0 to 3 at SLOT_BASE + 4·k, where SLOT_BASE = LUT_BASE + (LUT_SLOTS−1)·16. Last comes LOCK_KEY at LOCK_ADDR. With the defaults the slot base is 0x3F0 for 32 slots and 0x2F0 for 16 slots.
- R9: A write is accepted on a clock edge where reg_wr and reg_ready are both high. While reg_ready is low, reg_wr, reg_addr and reg_wdata hold their values. At most one write is accepted per cycle.
- R10: done is high for exactly one cycle, the cycle right after the lock write is accepted. reg_wr is low in that cycle.
- R11: A start pulse that arrives while a sequence is in progress is ignored. The sequence in progress keeps the words it captured at its own start, and no second sequence follows it.
- R12: After reset, reg_wr and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| op_code | input | 16 | Command code; only the low byte is used unless the command is double-rate |
| cmd_width | input | 4 | Command bus width: 1, 2, 4 or 8 |
| addr_width | input | 4 | Address bus width |
| dummy_width | input | 4 | Dummy phase bus width |
| data_width | input | 4 | Data bus width |
| addr_bytes | input | 3 | Address byte count; 0 means no address phase |
| dummy_bytes | input | 5 | Dummy byte count; 0 means no dummy phase |
| data_len | input | DLEN_W | Data byte count; 0 means no data phase |
| data_read | input | 1 | 1 for a read, 0 for a write |
| cmd_dtr | input | 1 | Command phase is double-rate |
| addr_dtr | input | 1 | Address phase is double-rate |
| dummy_dtr | input | 1 | Dummy phase is double-rate |
| data_dtr | input | 1 | Data phase is double-rate |
| reg_ready | input | 1 | Register bus can accept a write |
| reg_wr | output | 1 | Write request |
| reg_addr | output | AW | Write address |
| reg_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
A fault in the encoder changes the data of one of the four table writes. That shows up between one and four accepted writes after the unlock. A step counter that skips or repeats a value shows at once as a wrong address or a wrong write count. It also moves the done pulse away from the cycle right after the lock write. A write that changes while the bus is stalled, or a latch that picks up a second start, shows up within the same operation. The first appears as unstable reg_addr or reg_wdata while reg_ready is low. The second appears as changed words or extra writes after done.

// File: rtl/flut_pkg.sv
package flut_pkg;

  typedef logic [15:0] instr_t;

  localparam logic [5:0] OP_CMD       = 6'h01;
  localparam logic [5:0] OP_ADDR      = 6'h02;
  localparam logic [5:0] OP_DUMMY     = 6'h0C;
  localparam logic [5:0] OP_WRITE     = 6'h08;
  localparam logic [5:0] OP_READ      = 6'h09;
  localparam logic [5:0] OP_CMD_DDR   = 6'h21;
  localparam logic [5:0] OP_ADDR_DDR  = 6'h22;
  localparam logic [5:0] OP_DUMMY_DDR = 6'h2C;
  localparam logic [5:0] OP_WRITE_DDR = 6'h28;
  localparam logic [5:0] OP_READ_DDR  = 6'h29;

  typedef struct packed {
    logic [15:0] op_code;
    logic [3:0]  cmd_w;
    logic [3:0]  addr_w;
    logic [3:0]  dummy_w;
    logic [3:0]  data_w;
    logic [2:0]  addr_bytes;
    logic [4:0]  dummy_bytes;
    logic        has_data;
    logic        rd;
    logic        cmd_dtr;
    logic        addr_dtr;
    logic        dummy_dtr;
    logic        data_dtr;
  } desc_t;

  function automatic logic [1:0] width_to_pad(input logic [3:0] w);
    case (w)
      4'd2:    return 2'd1;
      4'd4:    return 2'd2;
      4'd8:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic instr_t mk_instr(input logic [5:0] op, input logic [1:0] pad,
                                      input logic [7:0] operand);
    return {op, pad, operand};
  endfunction

endpackage

// File: rtl/flut_seq_encoder.sv
module flut_seq_encoder
  import flut_pkg::*;
#(
  parameter int N_WORDS = 4
) (
  input  desc_t                    desc,
  output logic [N_WORDS*32-1:0]    words
);

  localparam int N_INSTR = 2 * N_WORDS;
  localparam int IX_W    = $clog2(N_INSTR);

  instr_t           slots [N_INSTR];
  logic [IX_W-1:0]  n;
  logic [1:0]       cpad, apad, dpad_data, dpad_own;
  logic [7:0]       dcyc;

  assign cpad      = width_to_pad(desc.cmd_w);
  assign apad      = width_to_pad(desc.addr_w);
  assign dpad_data = width_to_pad(desc.data_w);
  assign dpad_own  = width_to_pad(desc.dummy_w);
  assign dcyc      = {desc.dummy_bytes, 3'b000} >> dpad_own;

  always_comb begin
    for (int k = 0; k < N_INSTR; k++) slots[k] = '0;
    n = '0;
    // command phase
    if (desc.cmd_dtr) begin
      slots[n] = mk_instr(OP_CMD_DDR, cpad, desc.op_code[15:8]);
      n = n + 1'b1;
      slots[n] = mk_instr(OP_CMD_DDR, cpad, desc.op_code[7:0]);
      n = n + 1'b1;
    end else begin
      slots[n] = mk_instr(OP_CMD, cpad, desc.op_code[7:0]);
      n = n + 1'b1;
    end
    // address phase
    if (desc.addr_bytes != 3'd0) begin
      slots[n] = mk_instr(desc.addr_dtr ? OP_ADDR_DDR : OP_ADDR, apad,
                          {2'b00, desc.addr_bytes, 3'b000});
      n = n + 1'b1;
    end
    // dummy phase: pad follows the data width
    if (desc.dummy_bytes != 5'd0) begin
      slots[n] = mk_instr(desc.dummy_dtr ? OP_DUMMY_DDR : OP_DUMMY, dpad_data, dcyc);
      n = n + 1'b1;
    end
    // data phase
    if (desc.has_data) begin
      if (desc.rd) slots[n] = mk_instr(desc.data_dtr ? OP_READ_DDR  : OP_READ,  dpad_data, 8'h00);
      else         slots[n] = mk_instr(desc.data_dtr ? OP_WRITE_DDR : OP_WRITE, dpad_data, 8'h00);
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_pack
    assign words[w*32 +: 32] = {slots[2*w+1], slots[2*w]};
  end

endmodule

// File: rtl/flut_lut_writer.sv
module flut_lut_writer #(
  parameter int              N_WORDS    = 4,
  parameter int              AW         = 12,
  parameter logic [AW-1:0]   SLOT_BASE  = 12'h3F0,
  parameter logic [AW-1:0]   LOCK_ADDR  = 12'h018,
  parameter logic [31:0]     UNLOCK_KEY = 32'h5AF0_5AF2,
  parameter logic [31:0]     LOCK_KEY   = 32'h5AF0_5AF1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [N_WORDS*32-1:0]   words_in,
  input  logic                    reg_ready,
  output logic                    reg_wr,
  output logic [AW-1:0]           reg_addr,
  output logic [31:0]             reg_wdata,
  output logic                    done
);

  localparam int N_STEPS = N_WORDS + 2;
  localparam int SW      = $clog2(N_STEPS);
  localparam int WI      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam logic [SW-1:0] LAST = SW'(N_STEPS - 1);

  logic [31:0]    words_q [N_WORDS];
  logic [SW-1:0]  step, nxt;
  logic [WI-1:0]  wi;
  logic [AW-1:0]  nxt_addr;
  logic [31:0]    nxt_data;

  assign nxt = step + 1'b1;
  assign wi  = WI'(nxt - 1'b1);

  always_comb begin
    if (nxt == LAST) begin
      nxt_addr = LOCK_ADDR;
      nxt_data = LOCK_KEY;
    end else begin
      nxt_addr = SLOT_BASE + {wi, 2'b00};
      nxt_data = words_q[wi];
    end
  end

  always_ff @(posedge clk) begin
    if (start && !reg_wr)
      for (int k = 0; k < N_WORDS; k++) words_q[k] <= words_in[k*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      done      <= 1'b0;
      step      <= '0;
    end else begin
      done <= 1'b0;
      if (!reg_wr) begin
        if (start) begin
          step      <= '0;
          reg_wr    <= 1'b1;
          reg_addr  <= LOCK_ADDR;
          reg_wdata <= UNLOCK_KEY;
        end
      end else if (reg_ready) begin
        if (step == LAST) begin
          reg_wr <= 1'b0;
          done   <= 1'b1;
        end else begin
          step      <= nxt;
          reg_addr  <= nxt_addr;
          reg_wdata <= nxt_data;
        end
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    reg_wr && !reg_ready |=> reg_wr && $stable(reg_addr) && $stable(reg_wdata));

  assert_unlock_first_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_wr) |-> reg_addr == LOCK_ADDR && reg_wdata == UNLOCK_KEY);

  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(reg_wr && reg_ready && reg_addr == LOCK_ADDR && reg_wdata == LOCK_KEY));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_reset_state_R12: assert property (@(posedge clk)
    $past(rst) |-> !reg_wr && !done);

endmodule

// File: rtl/flut_seq_builder.sv
module flut_seq_builder
  import flut_pkg::*;
#(
  parameter int            LUT_SLOTS  = 32,
  parameter int            AW         = 12,
  parameter int            DLEN_W     = 16,
  parameter logic [AW-1:0] LUT_BASE   = 12'h200,
  parameter logic [AW-1:0] LOCK_ADDR  = 12'h018,
  parameter logic [31:0]   UNLOCK_KEY = 32'h5AF0_5AF2,
  parameter logic [31:0]   LOCK_KEY   = 32'h5AF0_5AF1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       op_code,
  input  logic [3:0]        cmd_width,
  input  logic [3:0]        addr_width,
  input  logic [3:0]        dummy_width,
  input  logic [3:0]        data_width,
  input  logic [2:0]        addr_bytes,
  input  logic [4:0]        dummy_bytes,
  input  logic [DLEN_W-1:0] data_len,
  input  logic              data_read,
  input  logic              cmd_dtr,
  input  logic              addr_dtr,
  input  logic              dummy_dtr,
  input  logic              data_dtr,
  input  logic              reg_ready,
  output logic              reg_wr,
  output logic [AW-1:0]     reg_addr,
  output logic [31:0]       reg_wdata,
  output logic              done
);

  localparam int            N_WORDS   = 4;
  localparam logic [AW-1:0] SLOT_BASE = LUT_BASE + AW'((LUT_SLOTS - 1) * N_WORDS * 4);

  desc_t                  desc;
  logic [N_WORDS*32-1:0]  words;

  assign desc = '{op_code: op_code, cmd_w: cmd_width, addr_w: addr_width,
                  dummy_w: dummy_width, data_w: data_width,
                  addr_bytes: addr_bytes, dummy_bytes: dummy_bytes,
                  has_data: |data_len, rd: data_read, cmd_dtr: cmd_dtr,
                  addr_dtr: addr_dtr, dummy_dtr: dummy_dtr, data_dtr: data_dtr};

  flut_seq_encoder #(.N_WORDS(N_WORDS)) u_enc (
    .desc  (desc),
    .words (words)
  );

  flut_lut_writer #(
    .N_WORDS    (N_WORDS),
    .AW         (AW),
    .SLOT_BASE  (SLOT_BASE),
    .LOCK_ADDR  (LOCK_ADDR),
    .UNLOCK_KEY (UNLOCK_KEY),
    .LOCK_KEY   (LOCK_KEY)
  ) u_wr (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .words_in  (words),
    .reg_ready (reg_ready),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .done      (done)
  );

endmodule

// File: tb/sim_flut_seq_builder.sv
module sim_flut_seq_builder;

  localparam logic [11:0] LOCK_A = 12'h018;
  localparam logic [31:0] UNLK   = 32'h5AF0_5AF2;
  localparam logic [31:0] LCK    = 32'h5AF0_5AF1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0] op_code = '0;
  logic [3:0]  cmd_width = 4'd1, addr_width = 4'd1, dummy_width = 4'd1, data_width = 4'd1;
  logic [2:0]  addr_bytes = '0;
  logic [4:0]  dummy_bytes = '0;
  logic [15:0] data_len = '0;
  logic data_read = 1'b0, cmd_dtr = 1'b0, addr_dtr = 1'b0, dummy_dtr = 1'b0, data_dtr = 1'b0;
  logic reg_ready = 1'b1;
  logic reg_wr, done, reg_wr1, done1;
  logic [11:0] reg_addr, reg_addr1;
  logic [31:0] reg_wdata, reg_wdata1;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  flut_seq_builder u0 (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code),
    .cmd_width(cmd_width), .addr_width(addr_width), .dummy_width(dummy_width),
    .data_width(data_width), .addr_bytes(addr_bytes), .dummy_bytes(dummy_bytes),
    .data_len(data_len), .data_read(data_read), .cmd_dtr(cmd_dtr),
    .addr_dtr(addr_dtr), .dummy_dtr(dummy_dtr), .data_dtr(data_dtr),
    .reg_ready(reg_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .done(done)
  );

  flut_seq_builder #(.LUT_SLOTS(16)) u1 (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code),
    .cmd_width(cmd_width), .addr_width(addr_width), .dummy_width(dummy_width),
    .data_width(data_width), .addr_bytes(addr_bytes), .dummy_bytes(dummy_bytes),
    .data_len(data_len), .data_read(data_read), .cmd_dtr(cmd_dtr),
    .addr_dtr(addr_dtr), .dummy_dtr(dummy_dtr), .data_dtr(data_dtr),
    .reg_ready(1'b1), .reg_wr(reg_wr1), .reg_addr(reg_addr1),
    .reg_wdata(reg_wdata1), .done(done1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_desc(input logic [15:0] opc, input logic [3:0] cw, aw, dw, tw,
                          input logic [2:0] ab, input logic [4:0] db, input logic [15:0] dl,
                          input logic rd, cd, ad, dd, td);
    op_code = opc; cmd_width = cw; addr_width = aw; dummy_width = dw; data_width = tw;
    addr_bytes = ab; dummy_bytes = db; data_len = dl; data_read = rd;
    cmd_dtr = cd; addr_dtr = ad; dummy_dtr = dd; data_dtr = td;
  endtask

  // Runs one operation on u0 and checks the full write sequence (R8),
  // the word contents (tag), the done timing (R10), optional stalls (R9)
  // and optional start injection while busy (R11).
  task automatic run_case(input string tag, input logic [31:0] e0, e1, e2, e3,
                          input bit stall, input bit inject);
    logic [11:0] a_q [8];
    logic [31:0] d_q [8];
    logic [31:0] exp_w [4];
    int nacc = 0, ndone = 0, done_at = -1;
    bit hold = 0, wr_at_done = 0;
    logic [11:0] pa = '0;
    logic [31:0] pd = '0;
    exp_w[0] = e0; exp_w[1] = e1; exp_w[2] = e2; exp_w[3] = e3;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 30; c++) begin
      reg_ready = stall ? (c % 3 == 2) : 1'b1;
      if (inject && c == 1) begin op_code = 16'hFFFF; cmd_dtr = 1'b1; start = 1'b1; end
      if (inject && c == 2) start = 1'b0;
      #1;
      if (hold) begin
        check(reg_wr && reg_addr == pa && reg_wdata == pd, "R9", "stalled write stable",
              {20'h0, reg_addr, reg_wdata}, {20'h0, pa, pd});
      end
      if (done) begin ndone++; done_at = nacc; wr_at_done = reg_wr; end
      if (reg_wr && reg_ready) begin
        if (nacc < 8) begin a_q[nacc] = reg_addr; d_q[nacc] = reg_wdata; end
        nacc++;
      end
      hold = reg_wr && !reg_ready;
      pa = reg_addr; pd = reg_wdata;
      @(negedge clk);
    end
    start = 1'b0; reg_ready = 1'b1;
    check(nacc == 6, "R8/R11", "write count", 64'(nacc), 64'd6);
    if (nacc >= 6) begin
      check(a_q[0] == LOCK_A && d_q[0] == UNLK, "R8", "unlock write",
            {20'h0, a_q[0], d_q[0]}, {20'h0, LOCK_A, UNLK});
      for (int k = 0; k < 4; k++) begin
        check(a_q[k+1] == 12'h3F0 + 12'(4*k), "R8", "slot address",
              64'(a_q[k+1]), 64'(12'h3F0 + 12'(4*k)));
        check(d_q[k+1] == exp_w[k], tag, $sformatf("word %0d", k),
              64'(d_q[k+1]), 64'(exp_w[k]));
      end
      check(a_q[5] == LOCK_A && d_q[5] == LCK, "R8", "lock write",
            {20'h0, a_q[5], d_q[5]}, {20'h0, LOCK_A, LCK});
    end
    check(ndone == 1 && done_at == 6 && !wr_at_done, "R10", "done pulse (count,index)",
          {32'(ndone), 32'(done_at)}, {32'd1, 32'd6});
  endtask

  task automatic t_reset;
    check(reg_wr == 1'b0, "R12", "reg_wr after reset", 64'(reg_wr), 64'd0);
    check(done == 1'b0, "R12", "done after reset", 64'(done), 64'd0);
  endtask

  task automatic t_small_table;
    logic [11:0] exp_a [6];
    int n = 0;
    exp_a[0] = LOCK_A; exp_a[1] = 12'h2F0; exp_a[2] = 12'h2F4;
    exp_a[3] = 12'h2F8; exp_a[4] = 12'h2FC; exp_a[5] = LOCK_A;
    set_desc(16'h0006, 4'd1, 4'd1, 4'd1, 4'd1, 3'd0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    reg_ready = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 12; c++) begin
      if (reg_wr1) begin
        if (n < 6) check(reg_addr1 == exp_a[n], "R8", "16-slot address",
                         64'(reg_addr1), 64'(exp_a[n]));
        n++;
      end
      @(negedge clk);
    end
    check(n == 6, "R8", "16-slot write count", 64'(n), 64'd6);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // single-rate read: 0x03, 3 address bytes, data read, all width 1
    set_desc(16'h0003, 4'd1, 4'd1, 4'd1, 4'd1, 3'd3, 5'd0, 16'd16, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case("R1/R3/R5/R7", 32'h0818_0403, 32'h0000_2400, 32'h0, 32'h0, 1'b0, 1'b0);
    // quad read with dummy: dummy pad from data width, cycles from dummy width
    set_desc(16'h00EB, 4'd1, 4'd4, 4'd1, 4'd4, 3'd3, 5'd3, 16'd64, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case("R6/R5", 32'h0A18_04EB, 32'h2600_3218, 32'h0, 32'h0, 1'b0, 1'b0);
    // octal all double-rate read
    set_desc(16'hEE11, 4'd8, 4'd8, 4'd8, 4'd8, 3'd4, 5'd20, 16'd32, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    run_case("R4/R2/R6", 32'h8711_87EE, 32'hB314_8B20, 32'h0000_A700, 32'h0, 1'b0, 1'b0);
    // command only: absent phases emit nothing
    set_desc(16'h0006, 4'd1, 4'd1, 4'd1, 4'd1, 3'd0, 5'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case("R2", 32'h0000_0406, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    // single-rate program with bus stalls
    set_desc(16'h0002, 4'd1, 4'd1, 4'd1, 4'd1, 3'd3, 5'd0, 16'd256, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case("R7/R9", 32'h0818_0402, 32'h0000_2000, 32'h0, 32'h0, 1'b1, 1'b0);
    // double-rate write; a second start arrives mid-sequence
    set_desc(16'h1234, 4'd8, 4'd8, 4'd8, 4'd8, 3'd4, 5'd0, 16'd8, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_case("R4/R7/R11", 32'h8734_8712, 32'hA300_8B20, 32'h0, 32'h0, 1'b1, 1'b1);
    t_small_table();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule